// File: doc/BRIEF.md
# BCD Calendar Time-of-Day Counter

This block keeps wall-clock time and date as seven packed-BCD fields: seconds, minutes, hours (24-hour), weekday, day of month, month and a two-digit year. Each field is one byte, with the tens digit in bits 7:4 and the units digit in bits 3:0. A one-cycle tick strobe, normally raised once per second by a prescaler elsewhere in the chip, advances the seconds. Carries ripple upward through a chain of BCD steppers. The day rollover looks up the length of the current month and applies a divisible-by-four leap rule to February. The year field wraps from 99 to 00, and years below 70 are read as the 2000s.

Software or a surrounding register block sets the time by raising the hold input. While hold is high, ticks are discarded and a load strobe copies all seven load inputs into the fields at once. When hold drops, the next tick counts on from the loaded values. After each tick that advances the time, the block raises an update-ended pulse for exactly one cycle.

A small Moore state machine drives the pulse. It has three states. `ST_RUN` means counting with no update just finished. `ST_ENDED` means the previous cycle advanced the time, and this state drives the pulse high. `ST_HELD` means hold is high. Every state makes the same three transitions, chosen in this priority order: hold high goes to `ST_HELD`; otherwise an accepted tick goes to `ST_ENDED`; otherwise the machine goes to `ST_RUN`. Because of this, back-to-back ticks keep the machine in `ST_ENDED` and give one pulse per tick.

Top module: `bcd_tod_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 00, day 01, month 01, year 00, and the update pulse is low.
- R2: A tick with hold low adds one to the seconds in packed BCD. A units digit of 9 becomes 0 with the tens digit incremented. Seconds 59 become 00 and carry into the minutes.
- R3: Minutes count 00 to 59 in the same way, and 59 becomes 00 with a carry into the hours.
- R4: Hours count 00 to 23, and 23 becomes 00 with a day carry.
- R5: A day carry adds one to the weekday, and weekday 06 wraps to 00.
- R6: A day carry advances the day of month from 01 up to the month length and then returns it to 01 with a carry into the month. Months 04, 06, 09 and 11 have 30 days. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days.
- R7: February (month 02) has 29 days when the year value is divisible by four (year 00 included) and 28 days otherwise.
- R8: Month 12 wraps to 01 with a carry into the year, and year 99 wraps to 00.
- R9: While hold is high, ticks change nothing. A load strobe with hold high puts all seven load inputs on the outputs after the next clock edge. A load strobe with hold low is ignored.
- R10: The update pulse is high for the one cycle after each clock edge at which a tick with hold low was accepted, and low otherwise. Ticks on consecutive cycles give consecutive pulses.
- R11: A field whose value is at or above its last legal value wraps to its first value when it is carried into. For example, day 31 loaded into April rolls to day 01 of May.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance strobe |
| hold_i | input | 1 | Freeze counting and allow loading |
| load_i | input | 1 | Load strobe, effective only with hold high |
| ld_sec_i | input | 8 | Seconds value to load (BCD) |
| ld_min_i | input | 8 | Minutes value to load (BCD) |
| ld_hr_i | input | 8 | Hours value to load (BCD) |
| ld_wday_i | input | 8 | Weekday value to load (BCD) |
| ld_mday_i | input | 8 | Day-of-month value to load (BCD) |
| ld_mon_i | input | 8 | Month value to load (BCD) |
| ld_yr_i | input | 8 | Year value to load (BCD) |
| sec_o | output | 8 | Current seconds (BCD) |
| min_o | output | 8 | Current minutes (BCD) |
| hr_o | output | 8 | Current hours (BCD) |
| wday_o | output | 8 | Current weekday (BCD) |
| mday_o | output | 8 | Current day of month (BCD) |
| mon_o | output | 8 | Current month (BCD) |
| yr_o | output | 8 | Current year (BCD) |
| upd_done_o | output | 1 | One-cycle update-ended pulse |

## Verification
The assertions check on every cycle that the pulse follows an accepted tick and appears at no other time. They also check that every field stays frozen when no tick is accepted or while hold is high without a load, that a held load takes effect, and that seconds, hours, weekday and year wrap at their limits. The month-length table, the leap February decision, carries into an over-range loaded day, and long runs of consecutive ticks can only be shown by the bench's scenarios. In those scenarios an independent calendar model predicts each update and a monitor compares it against the fields.

// File: rtl/bcd_tod_pkg.sv
package bcd_tod_pkg;

    localparam int FIELD_W = 8;
    localparam int DIGIT_W = FIELD_W / 2;

    typedef logic [FIELD_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t sec;
        bcd_t mins;
        bcd_t hrs;
        bcd_t wday;
        bcd_t mday;
        bcd_t mon;
        bcd_t yr;
    } tod_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HELD  = 2'd1,
        ST_ENDED = 2'd2
    } tod_state_e;

    localparam bcd_t SEC_LAST  = 8'h59;
    localparam bcd_t MIN_LAST  = 8'h59;
    localparam bcd_t HR_LAST   = 8'h23;
    localparam bcd_t WDAY_LAST = 8'h06;
    localparam bcd_t MON_LAST  = 8'h12;
    localparam bcd_t YR_LAST   = 8'h99;
    localparam bcd_t ZERO_BCD  = 8'h00;
    localparam bcd_t ONE_BCD   = 8'h01;

    localparam tod_t TOD_RESET = '{
        sec: ZERO_BCD, mins: ZERO_BCD, hrs: ZERO_BCD, wday: ZERO_BCD,
        mday: ONE_BCD, mon: ONE_BCD, yr: ZERO_BCD
    };

endpackage

// File: rtl/bcd_tod_step.sv
module bcd_tod_step
    import bcd_tod_pkg::*;
(
    input  bcd_t cur_i,
    input  bcd_t first_i,
    input  bcd_t last_i,
    input  logic en_i,
    output bcd_t nxt_o,
    output logic wrap_o
);

    localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);
    localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

    logic [DIGIT_W-1:0] tens;
    logic [DIGIT_W-1:0] units;
    logic               at_end;

    always_comb begin
        tens   = cur_i[FIELD_W-1:DIGIT_W];
        units  = cur_i[DIGIT_W-1:0];
        at_end = (cur_i >= last_i);
        wrap_o = en_i && at_end;
        if (!en_i) begin
            nxt_o = cur_i;
        end else if (at_end) begin
            nxt_o = first_i;
        end else if (units >= NINE) begin
            nxt_o = {tens + ONE, {DIGIT_W{1'b0}}};
        end else begin
            nxt_o = {tens, units + ONE};
        end
    end

endmodule

// File: rtl/bcd_tod_mlen.sv
module bcd_tod_mlen
    import bcd_tod_pkg::*;
(
    input  bcd_t mon_i,
    input  bcd_t yr_i,
    output bcd_t last_day_o
);

    logic [1:0] rem4;
    logic       leap;

    // value = 10*t + u, so value mod 4 = (2*t[0] + u[1:0]) mod 4
    always_comb begin
        rem4 = yr_i[1:0] + {yr_i[DIGIT_W], 1'b0};
        leap = (rem4 == 2'd0);
        unique case (mon_i)
            8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
            default:                    last_day_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_tod_counter.sv
module bcd_tod_counter
    import bcd_tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       hold_i,
    input  logic       load_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hr_i,
    input  logic [7:0] ld_wday_i,
    input  logic [7:0] ld_mday_i,
    input  logic [7:0] ld_mon_i,
    input  logic [7:0] ld_yr_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] yr_o,
    output logic       upd_done_o
);

    tod_state_e state_q, state_d;
    tod_t       tod_q, tod_nxt;
    logic       advance, take_load;
    logic       c_min, c_hr, c_day, c_mon, c_yr;
    logic       w_wday, w_yr;
    bcd_t       mday_last;

    assign advance   = tick_i && !hold_i;
    assign take_load = hold_i && load_i;

    // carry chain: seconds -> minutes -> hours -> day -> month -> year
    bcd_tod_step u_sec (
        .cur_i(tod_q.sec), .first_i(ZERO_BCD), .last_i(SEC_LAST),
        .en_i(advance), .nxt_o(tod_nxt.sec), .wrap_o(c_min)
    );
    bcd_tod_step u_min (
        .cur_i(tod_q.mins), .first_i(ZERO_BCD), .last_i(MIN_LAST),
        .en_i(c_min), .nxt_o(tod_nxt.mins), .wrap_o(c_hr)
    );
    bcd_tod_step u_hr (
        .cur_i(tod_q.hrs), .first_i(ZERO_BCD), .last_i(HR_LAST),
        .en_i(c_hr), .nxt_o(tod_nxt.hrs), .wrap_o(c_day)
    );
    bcd_tod_step u_wday (
        .cur_i(tod_q.wday), .first_i(ZERO_BCD), .last_i(WDAY_LAST),
        .en_i(c_day), .nxt_o(tod_nxt.wday), .wrap_o(w_wday)
    );
    bcd_tod_mlen u_mlen (
        .mon_i(tod_q.mon), .yr_i(tod_q.yr), .last_day_o(mday_last)
    );
    bcd_tod_step u_mday (
        .cur_i(tod_q.mday), .first_i(ONE_BCD), .last_i(mday_last),
        .en_i(c_day), .nxt_o(tod_nxt.mday), .wrap_o(c_mon)
    );
    bcd_tod_step u_mon (
        .cur_i(tod_q.mon), .first_i(ONE_BCD), .last_i(MON_LAST),
        .en_i(c_mon), .nxt_o(tod_nxt.mon), .wrap_o(c_yr)
    );
    bcd_tod_step u_yr (
        .cur_i(tod_q.yr), .first_i(ZERO_BCD), .last_i(YR_LAST),
        .en_i(c_yr), .nxt_o(tod_nxt.yr), .wrap_o(w_yr)
    );

    // time registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tod_q <= TOD_RESET;
        end else if (take_load) begin
            tod_q <= '{sec: ld_sec_i, mins: ld_min_i, hrs: ld_hr_i,
                       wday: ld_wday_i, mday: ld_mday_i, mon: ld_mon_i,
                       yr: ld_yr_i};
        end else if (advance) begin
            tod_q <= tod_nxt;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_ENDED, ST_HELD: begin
                if (hold_i)       state_d = ST_HELD;
                else if (tick_i)  state_d = ST_ENDED;
                else              state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        upd_done_o = (state_q == ST_ENDED);
        sec_o      = tod_q.sec;
        min_o      = tod_q.mins;
        hr_o       = tod_q.hrs;
        wday_o     = tod_q.wday;
        mday_o     = tod_q.mday;
        mon_o      = tod_q.mon;
        yr_o       = tod_q.yr;
    end

endmodule

// File: rtl/bcd_tod_chk.sv
module bcd_tod_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       hold_i,
    input logic       load_i,
    input logic [7:0] ld_sec_i,
    input logic [7:0] ld_min_i,
    input logic [7:0] ld_hr_i,
    input logic [7:0] ld_wday_i,
    input logic [7:0] ld_mday_i,
    input logic [7:0] ld_mon_i,
    input logic [7:0] ld_yr_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hr_o,
    input logic [7:0] wday_o,
    input logic [7:0] mday_o,
    input logic [7:0] mon_o,
    input logic [7:0] yr_o,
    input logic       upd_done_o
);

    logic        acc;
    logic [55:0] all_f;

    assign acc   = tick_i && !hold_i;
    assign all_f = {sec_o, min_o, hr_o, wday_o, mday_o, mon_o, yr_o};

    a_r10_pulse_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> upd_done_o);

    a_r10_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !upd_done_o);

    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_i) |=> $stable(all_f));

    a_r9_idle_or_stray_load_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(hold_i && load_i)) |=> $stable(all_f));

    a_r9_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && load_i) |=> all_f == $past({ld_sec_i, ld_min_i, ld_hr_i,
            ld_wday_i, ld_mday_i, ld_mon_i, ld_yr_i}));

    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sec_o == 8'h59) |=> sec_o == 8'h00);

    a_r4_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sec_o == 8'h59 && min_o == 8'h59 && hr_o == 8'h23) |=> hr_o == 8'h00);

    a_r5_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sec_o == 8'h59 && min_o == 8'h59 && hr_o == 8'h23 && wday_o == 8'h06)
        |=> wday_o == 8'h00);

    a_r8_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sec_o == 8'h59 && min_o == 8'h59 && hr_o == 8'h23 &&
         mday_o == 8'h31 && mon_o == 8'h12 && yr_o == 8'h99)
        |=> (yr_o == 8'h00 && mon_o == 8'h01 && mday_o == 8'h01));

endmodule

bind bcd_tod_counter bcd_tod_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(hold_i), .load_i(load_i),
    .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hr_i(ld_hr_i),
    .ld_wday_i(ld_wday_i), .ld_mday_i(ld_mday_i), .ld_mon_i(ld_mon_i),
    .ld_yr_i(ld_yr_i), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o),
    .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .yr_o(yr_o),
    .upd_done_o(upd_done_o)
);

// File: tb/bcd_tod_counter_tb_top.sv
module bcd_tod_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hold = 1'b0;
    logic       load = 1'b0;
    logic [7:0] l_sec = 8'h00, l_min = 8'h00, l_hr = 8'h00, l_wd = 8'h00;
    logic [7:0] l_md = 8'h01, l_mo = 8'h01, l_yr = 8'h00;
    logic [7:0] sec_o, min_o, hr_o, wday_o, mday_o, mon_o, yr_o;
    logic       upd_done_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [55:0] exp_q[$];
    string       tag_q[$];

    int ms, mm, mh, mw, md, mo, my;

    always #4 clk = ~clk;

    bcd_tod_counter dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(hold), .load_i(load),
        .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hr_i(l_hr), .ld_wday_i(l_wd),
        .ld_mday_i(l_md), .ld_mon_i(l_mo), .ld_yr_i(l_yr),
        .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .yr_o(yr_o), .upd_done_o(upd_done_o)
    );

    function automatic logic [7:0] tob(int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int month_days(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] model_vec();
        return {tob(ms), tob(mm), tob(mh), tob(mw), tob(md), tob(mo), tob(my)};
    endfunction

    function automatic logic [55:0] dut_vec();
        return {sec_o, min_o, hr_o, wday_o, mday_o, mon_o, yr_o};
    endfunction

    task automatic model_step();
        if (ms < 59) begin ms++; return; end
        ms = 0;
        if (mm < 59) begin mm++; return; end
        mm = 0;
        if (mh < 23) begin mh++; return; end
        mh = 0;
        mw = (mw >= 6) ? 0 : mw + 1;
        if (md < month_days(mo, my)) begin md++; return; end
        md = 1;
        if (mo < 12) begin mo++; return; end
        mo = 1;
        my = (my >= 99) ? 0 : my + 1;
    endtask

    task automatic check(string tag, logic [55:0] act, logic [55:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: compares each update pulse against the scoreboard
    always @(negedge clk) begin
        if (rst_n && upd_done_o) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected pulse", 56'd1, 56'd0);
            end else begin
                check(tag_q.pop_front(), dut_vec(), exp_q.pop_front());
            end
        end
    end

    task automatic do_tick(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            model_step();
            exp_q.push_back(model_vec());
            tag_q.push_back(tag);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_all(int s, int m, int h, int w, int d, int mon, int y);
        @(negedge clk);
        hold = 1'b1;
        load = 1'b1;
        l_sec = tob(s); l_min = tob(m); l_hr = tob(h); l_wd = tob(w);
        l_md = tob(d); l_mo = tob(mon); l_yr = tob(y);
        @(negedge clk);
        load = 1'b0;
        hold = 1'b0;
        ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
        check("R9 load under hold", dut_vec(), model_vec());
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset fields", dut_vec(), {8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00});
        check("R1 reset pulse low", {55'd0, upd_done_o}, 56'd0);
        rst_n = 1'b1;
        ms = 0; mm = 0; mh = 0; mw = 0; md = 1; mo = 1; my = 0;

        do_tick(1, "R2 first tick from reset");
        // R2 units 9 carries into tens
        load_all(8, 0, 0, 0, 1, 1, 0);
        do_tick(3, "R2 BCD digit carry");
        // R3 minutes wrap into hours
        load_all(58, 59, 10, 2, 15, 6, 23);
        do_tick(3, "R3 minute wrap");
        // R4 R5 R6 midnight, weekday wrap, 31-day month end
        load_all(57, 59, 23, 6, 31, 1, 23);
        do_tick(3, "R4 R5 R6 day rollover");
        // R7 February
        load_all(59, 59, 23, 1, 28, 2, 23);
        do_tick(1, "R7 non-leap February");
        load_all(59, 59, 23, 1, 28, 2, 24);
        do_tick(1, "R7 leap February 28");
        load_all(59, 59, 23, 1, 29, 2, 24);
        do_tick(1, "R7 leap February 29");
        load_all(59, 59, 23, 3, 28, 2, 0);
        do_tick(1, "R7 year 00 leap");
        load_all(59, 59, 23, 3, 28, 2, 10);
        do_tick(1, "R7 odd-tens non-leap");
        load_all(59, 59, 23, 3, 28, 2, 12);
        do_tick(1, "R7 odd-tens leap");
        // R6 30- and 31-day months
        load_all(59, 59, 23, 0, 30, 4, 23);
        do_tick(1, "R6 April end");
        load_all(59, 59, 23, 0, 30, 9, 23);
        do_tick(1, "R6 September end");
        load_all(59, 59, 23, 0, 30, 11, 23);
        do_tick(1, "R6 November end");
        load_all(59, 59, 23, 0, 30, 8, 23);
        do_tick(1, "R6 August 30 not end");
        // R8 year wrap
        load_all(59, 59, 23, 5, 31, 12, 99);
        do_tick(1, "R8 year 99 wrap");
        // R11 over-range day
        load_all(59, 59, 23, 2, 31, 4, 23);
        do_tick(1, "R11 day above month length");

        // R9 ticks ignored under hold
        load_all(10, 20, 5, 1, 12, 3, 45);
        @(negedge clk);
        hold = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            check("R9 tick under hold ignored", dut_vec(), model_vec());
            check("R10 no pulse under hold", {55'd0, upd_done_o}, 56'd0);
        end
        hold = 1'b0;
        // R9 load without hold ignored
        @(negedge clk);
        load = 1'b1;
        l_sec = 8'h33; l_min = 8'h44; l_hr = 8'h11; l_yr = 8'h77;
        @(negedge clk);
        load = 1'b0;
        check("R9 load without hold ignored", dut_vec(), model_vec());
        do_tick(1, "R9 resume after hold");

        // R10 pulse width
        @(negedge clk);
        tick = 1'b1;
        model_step();
        exp_q.push_back(model_vec());
        tag_q.push_back("R10 single tick");
        @(negedge clk);
        tick = 1'b0;
        check("R10 pulse high after tick", {55'd0, upd_done_o}, 56'd1);
        @(negedge clk);
        check("R10 pulse lasts one cycle", {55'd0, upd_done_o}, 56'd0);

        // R10 long run of consecutive ticks through several carries
        load_all(30, 58, 23, 6, 28, 2, 96);
        do_tick(200, "R10 consecutive ticks");

        repeat (3) @(negedge clk);
        check("R10 every tick produced a pulse", 56'(exp_q.size()), 56'd0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule